// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block turns a serial line into parallel characters. While idle it waits for the line to go high and then low again, which marks the leading edge of a start bit. Half a bit time later it looks at the line a second time. If the line has gone high again, the low was a glitch and the block goes back to waiting. If the start bit holds, the block takes one sample per bit time at the centre of each data bit, then of the optional parity bit, then of the stop bit. After the stop sample it moves the character into a receive buffer and flags it as ready for the host.

Bit timing comes from `rxTick`, a one-cycle enable that runs at 1, 16 or 64 times the baud rate. The host reads the character from `rxData` while `rxReady` is high and pulses `readStrobe` to acknowledge it. Each buffered character carries a parity error flag and a framing error flag. A separate overrun flag records that a character was lost because the host was late.

Top module: `serial_rx`

## Requirements
- R1: While reset is asserted and directly after it, `rxReady`, `rxData`, `parityErr`, `frameErr` and `overrun` are all zero.
- R2: A start is accepted only on a low that follows a high sampled while waiting. A line that stays low after a character does not start a new one until it has been high.
- R3: A low on the line that has ended by the middle of the start bit is dropped with no character produced, and the next valid character is received correctly.
- R4: Data bits arrive least significant bit first. `charLen` selects 5 (00), 6 (01), 7 (10) or 8 (11) data bits, and the character is presented right-justified in `rxData` with the unused upper bits zero.
- R5: `rateSel` selects the tick-to-baud ratio: 00 gives 1x, 01 gives 16x, and 10 or 11 give 64x. At 16x and 64x the start bit is confirmed half a bit time after the edge. Every later sample follows the one before it by exactly one bit time.
- R6: With `parityEn` high, one parity bit follows the data bits. `parityOdd`=0 expects an even number of ones over the data and parity bits together, and `parityOdd`=1 expects an odd number. On a mismatch `parityErr` is high alongside the character.
- R7: `frameErr` is high alongside a character whose stop bit was sampled low, and low otherwise.
- R8: `rxReady` goes high once a character is in the buffer. A `readStrobe` pulse clears it when no new character completes in the same cycle.
- R9: If a character completes while `rxReady` is still high and no read occurs in that cycle, `overrun` is set and the new character replaces the old one. A read clears `overrun`.
- R10: With `parityEn` low, no parity bit is expected: the stop bit directly follows the data bits, and `parityErr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxTick | input | 1 | Sampling enable at 1x, 16x or 64x the baud rate |
| rateSel | input | 2 | Tick-to-baud ratio select |
| charLen | input | 2 | Data bits per character, 5 to 8 |
| parityEn | input | 1 | Parity bit present |
| parityOdd | input | 1 | Odd parity when high, even parity when low |
| rxLine | input | 1 | Serial input, idles high |
| readStrobe | input | 1 | Host acknowledges the buffered character |
| rxData | output | 8 | Buffered character, right-justified |
| rxReady | output | 1 | A character is waiting in the buffer |
| parityErr | output | 1 | The buffered character failed its parity check |
| frameErr | output | 1 | The buffered character's stop bit was low |
| overrun | output | 1 | A character was overwritten before it was read |

## Verification
The hardest states to reach from the ports are the ones where the line is low but no start should be taken. One is a low that ends before the mid-start check. The other is a line that stays low through and after a stop bit. The bench drives a two-tick low pulse at 16x and checks that no character appears and that a normal character afterwards is still received correctly. It also holds the line low for several character times from idle. This should yield exactly one all-zero character with a framing error and no further characters, because the block must wait for a high before it accepts another start.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  // Receiver sequencing states
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rxState_e;

  // Strobes from control to datapath, each one cycle wide
  typedef struct packed {
    logic clearShift;   // start bit confirmed, clear the assembly register
    logic shiftBit;     // capture one data bit
    logic takeParity;   // capture the parity bit
    logic finish;       // stop bit sampled, load the buffer
  } rxStrobe_t;

  localparam int unsigned TICK_CNT_W = 6;

endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxTick,
  input  logic       rxSync,
  input  logic [1:0] rateSel,
  input  logic [1:0] charLen,
  input  logic       parityEn,
  output rxStrobe_t  strobes
);

  localparam int BIT_W = $clog2(DATA_W + 1);

  rxState_e                  state;
  logic [TICK_CNT_W-1:0]     tickCnt;
  logic [TICK_CNT_W-1:0]     fullM1;
  logic [TICK_CNT_W-1:0]     halfM1;
  logic [BIT_W-1:0]          bitsLeft;
  logic [BIT_W-1:0]          dataBits;
  logic                      armed;
  logic                      rate1x;
  logic                      atSample;

  // Ticks per bit minus one, and ticks to the middle of the start bit minus one
  always_comb begin
    case (rateSel)
      2'b00:   begin fullM1 = 6'd0;  halfM1 = 6'd0;  end
      2'b01:   begin fullM1 = 6'd15; halfM1 = 6'd7;  end
      default: begin fullM1 = 6'd63; halfM1 = 6'd31; end
    endcase
  end

  assign rate1x   = (rateSel == 2'b00);
  assign dataBits = BIT_W'(DATA_W - 3) + BIT_W'(charLen);
  assign atSample = rxTick && (tickCnt == '0);

  always_comb begin
    strobes            = '0;
    strobes.clearShift = (state == ST_HUNT  && rxTick && armed && !rxSync && rate1x) ||
                         (state == ST_START && atSample && !rxSync);
    strobes.shiftBit   = (state == ST_DATA)   && atSample;
    strobes.takeParity = (state == ST_PARITY) && atSample;
    strobes.finish     = (state == ST_STOP)   && atSample;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_HUNT;
      tickCnt  <= '0;
      bitsLeft <= '0;
      armed    <= 1'b0;
    end else if (rxTick) begin
      case (state)
        ST_HUNT: begin
          if (rxSync) begin
            armed <= 1'b1;
          end else if (armed) begin
            if (rate1x) begin
              state    <= ST_DATA;
              tickCnt  <= fullM1;
              bitsLeft <= dataBits;
            end else begin
              state    <= ST_START;
              tickCnt  <= halfM1;
            end
          end
        end
        ST_START: begin
          if (tickCnt != '0) begin
            tickCnt <= tickCnt - 6'd1;
          end else if (rxSync) begin
            state <= ST_HUNT;
            armed <= 1'b1;
          end else begin
            state    <= ST_DATA;
            tickCnt  <= fullM1;
            bitsLeft <= dataBits;
          end
        end
        ST_DATA: begin
          if (tickCnt != '0) begin
            tickCnt <= tickCnt - 6'd1;
          end else begin
            tickCnt  <= fullM1;
            bitsLeft <= bitsLeft - BIT_W'(1);
            if (bitsLeft == BIT_W'(1)) begin
              state <= parityEn ? ST_PARITY : ST_STOP;
            end
          end
        end
        ST_PARITY: begin
          if (tickCnt != '0) begin
            tickCnt <= tickCnt - 6'd1;
          end else begin
            tickCnt <= fullM1;
            state   <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (tickCnt != '0) begin
            tickCnt <= tickCnt - 6'd1;
          end else begin
            state <= ST_HUNT;
            armed <= rxSync;
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/serial_rx_datapath.sv
module serial_rx_datapath
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic [1:0]        charLen,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              readStrobe,
  input  rxStrobe_t         strobes,
  output logic              rxSync,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              parityErr,
  output logic              frameErr,
  output logic              overrun
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic [DATA_W-1:0]      shiftReg;
  logic                   parAcc;
  logic [1:0]             gap;

  // Metastability guard on the serial input, idles high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '1;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], rxLine};
  end
  assign rxSync = syncChain[SYNC_STAGES-1];

  // Bits enter at the top so the first bit ends up lowest
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
    end else if (strobes.clearShift) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
    end else if (strobes.shiftBit) begin
      shiftReg <= {rxSync, shiftReg[DATA_W-1:1]};
      parAcc   <= parAcc ^ rxSync;
    end else if (strobes.takeParity) begin
      parAcc   <= parAcc ^ rxSync;
    end
  end

  assign gap = 2'd3 - charLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData    <= '0;
      rxReady   <= 1'b0;
      parityErr <= 1'b0;
      frameErr  <= 1'b0;
      overrun   <= 1'b0;
    end else if (strobes.finish) begin
      rxData    <= shiftReg >> gap;
      rxReady   <= 1'b1;
      parityErr <= parityEn & (parAcc ^ parityOdd);
      frameErr  <= ~rxSync;
      if (rxReady && !readStrobe) overrun <= 1'b1;
      else if (readStrobe)        overrun <= 1'b0;
    end else if (readStrobe) begin
      rxReady <= 1'b0;
      overrun <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxTick,
  input  logic [1:0]        rateSel,
  input  logic [1:0]        charLen,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              rxLine,
  input  logic              readStrobe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              parityErr,
  output logic              frameErr,
  output logic              overrun
);

  rxStrobe_t strobes;
  logic      rxSync;

  serial_rx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rxTick   (rxTick),
    .rxSync   (rxSync),
    .rateSel  (rateSel),
    .charLen  (charLen),
    .parityEn (parityEn),
    .strobes  (strobes)
  );

  serial_rx_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(2)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxLine     (rxLine),
    .charLen    (charLen),
    .parityEn   (parityEn),
    .parityOdd  (parityOdd),
    .readStrobe (readStrobe),
    .strobes    (strobes),
    .rxSync     (rxSync),
    .rxData     (rxData),
    .rxReady    (rxReady),
    .parityErr  (parityErr),
    .frameErr   (frameErr),
    .overrun    (overrun)
  );

endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk (
  input logic clk,
  input logic rstN,
  input logic readStrobe,
  input logic parityEn,
  input logic finish,
  input logic rxReady,
  input logic overrun,
  input logic parityErr
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rstN |=> (!rxReady && !overrun && !parityErr));

  // R8
  ready_set_chk: assert property (@(posedge clk) disable iff (!rstN) finish |=> rxReady);

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readStrobe && !finish) |=> (!rxReady && !overrun));

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (finish && rxReady && !readStrobe) |=> overrun);

  // R10
  no_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (finish && !parityEn) |=> !parityErr);

endmodule

bind serial_rx serial_rx_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .readStrobe (readStrobe),
  .parityEn   (parityEn),
  .finish     (strobes.finish),
  .rxReady    (rxReady),
  .overrun    (overrun),
  .parityErr  (parityErr)
);

// File: tb/serial_rx_test.sv
module serial_rx_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxTick = 1'b0;
  logic [1:0] rateSel = 2'b01;
  logic [1:0] charLen = 2'b11;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       rxLine = 1'b1;
  logic       readStrobe = 1'b0;
  logic [7:0] rxData;
  logic       rxReady, parityErr, frameErr, overrun;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;
  always @(negedge clk) rxTick <= ~rxTick;   // one tick every two clocks

  serial_rx uut (
    .clk(clk), .rstN(rstN), .rxTick(rxTick), .rateSel(rateSel), .charLen(charLen),
    .parityEn(parityEn), .parityOdd(parityOdd), .rxLine(rxLine), .readStrobe(readStrobe),
    .rxData(rxData), .rxReady(rxReady), .parityErr(parityErr), .frameErr(frameErr),
    .overrun(overrun)
  );

  // fields: rate[15:14] len[13:12] parEn[11] parOdd[10] badPar[9] stop[8] data[7:0]
  localparam logic [15:0] VEC [8] = '{
    {2'b01, 2'b11, 4'b0001, 8'h49},   // 16x, 8 bits, no parity
    {2'b01, 2'b10, 4'b1001, 8'h47},   // 16x, 7 bits, even parity
    {2'b01, 2'b11, 4'b1101, 8'hA5},   // 16x, 8 bits, odd parity
    {2'b00, 2'b00, 4'b0001, 8'h3F},   // 1x, 5 bits
    {2'b10, 2'b01, 4'b1001, 8'hC9},   // 64x, 6 bits, even parity
    {2'b01, 2'b11, 4'b1111, 8'h5C},   // 16x, odd parity, wrong parity bit
    {2'b01, 2'b10, 4'b0000, 8'h33},   // 16x, 7 bits, stop low
    {2'b00, 2'b11, 4'b1010, 8'h00}    // 1x, even parity, wrong parity bit
  };

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
    end
  endtask

  function automatic int multOf(logic [1:0] r);
    return (r == 2'b00) ? 1 : (r == 2'b01) ? 16 : 64;
  endfunction

  task automatic holdLine(logic b, int clocks);
    rxLine = b;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic sendChar(logic [7:0] d, logic [1:0] len, logic pe, logic po,
                          logic bad, logic stopB);
    int bitClk;
    int n;
    logic par;
    bitClk = multOf(rateSel) * 2;
    n = 5 + int'(len);
    par = po ^ bad;
    holdLine(1'b0, bitClk);
    for (int i = 0; i < n; i++) begin
      par ^= d[i];
      holdLine(d[i], bitClk);
    end
    if (pe) holdLine(par, bitClk);
    holdLine(stopB, bitClk);
    holdLine(1'b1, 2 * bitClk);
  endtask

  task automatic doRead();
    @(negedge clk) readStrobe = 1'b1;
    @(negedge clk) readStrobe = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 rxReady", rxReady, 0);
    check("R1 rxData", rxData, 0);
    check("R1 flags", {parityErr, frameErr, overrun}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {rxReady, parityErr, frameErr, overrun}, 0);

    // R2: idle high line produces nothing
    holdLine(1'b1, 400);
    check("R2 idle", rxReady, 0);

    // R4 R5 R6 R7 R10 vector walk
    for (int v = 0; v < 8; v++) begin
      logic [15:0] e;
      logic [7:0] mask;
      e = VEC[v];
      rateSel = e[15:14]; charLen = e[13:12];
      parityEn = e[11]; parityOdd = e[10];
      @(negedge clk);
      sendChar(e[7:0], e[13:12], e[11], e[10], e[9], e[8]);
      mask = 8'hFF >> (3 - int'(e[13:12]));
      check("R8 ready", rxReady, 1);
      check("R4 R5 data", rxData, e[7:0] & mask);
      check("R6 R10 parity", parityErr, e[11] & e[9]);
      check("R7 framing", frameErr, !e[8]);
      doRead();
      check("R8 read clears", rxReady, 0);
    end

    // R3: short glitch at 16x, then a valid character
    rateSel = 2'b01; charLen = 2'b11; parityEn = 1'b0;
    holdLine(1'b1, 40);
    holdLine(1'b0, 4);
    holdLine(1'b1, 32 * 12);
    check("R3 glitch dropped", rxReady, 0);
    sendChar(8'h5A, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R3 next char", rxData, 8'h5A);
    check("R3 next ready", rxReady, 1);
    doRead();

    // R9: overrun
    sendChar(8'h11, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1);
    sendChar(8'h22, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R9 overrun set", overrun, 1);
    check("R9 newest kept", rxData, 8'h22);
    doRead();
    check("R9 read clears", {rxReady, overrun}, 0);

    // R2: line held low from idle gives one zero character with framing error only
    holdLine(1'b0, 32 * 30);
    check("R2 one char", rxReady, 1);
    check("R2 zero data", rxData, 0);
    check("R2 frame", frameErr, 1);
    doRead();
    holdLine(1'b0, 32 * 30);
    check("R2 no restart while low", rxReady, 0);
    holdLine(1'b1, 64);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule